// File: doc/BRIEF.md
# Compare-Match Tick Timer

This block keeps a free-running 63-bit tick count that advances once per clock. A comparison register holds a limit value. When the running count reaches an armed limit, the timer raises a sticky match bit for a soft-interrupt source and sends a single-cycle wake pulse toward the processor. The nominal tick rate is 100 MHz, and the clock of the block is that tick.

Software reaches the timer through a small register port with 64-bit data. It can load the count, read the count, and load the limit. Bit 63 of each written word is a shared disable flag. The low 63 bits are the count or the compare value. A read returns the running count with the disable flag in bit 63. A limit arms the timer once. The limit is consumed when the count reaches it. Firing again takes a new limit write.

Top module: `tick_cmp_timer`

## Requirements
- R1: While `rst` is high, the count clears to zero and the disable flag is set, so `rd_count` reads 0x8000_0000_0000_0000. `match_flag` and `wake` are low. The cycle that follows the release of reset reads 1 in bits 62:0.
- R2: A `wr_count` strobe loads `wr_data[62:0]` into the count on that clock edge. With no strobe, the count rises by one on each clock.
- R3: `rd_count[62:0]` is the running count and `rd_count[63]` is the disable flag. A 1 in bit 63 means disabled.
- R4: The disable flag is a single flag with one source per write. On a `wr_count` or `wr_limit` strobe it takes `wr_data[63]` at that edge. On a `wr_limit` strobe, `wr_data[62:0]` becomes the compare value.
- R5: A limit write whose bits 62:0 are zero leaves the timer unarmed, so it never produces a wake or a match.
- R6: Suppose a limit L (with bit 63 clear) is written on the edge where the count read C, and L > C. Then `wake` and `match_flag` rise on the edge L−C clock cycles after the write edge.
- R7: A limit L ≤ C fires on the first clock edge after the write edge.
- R8: A limit written with bit 63 set stays unarmed. If the count reaches an armed limit while the flag is set, the arm is used up and no match or wake results. Clearing the flag afterwards does not bring the arm back.
- R9: Each armed limit fires at most once. Moving the count below the limit again gives no second wake unless the limit is written again.
- R10: `match_flag` stays high until a `clr_match` strobe clears it on the next edge. If a fire and a clear land on the same edge, the fire wins.
- R11: The count wraps from 0x7FFF_FFFF_FFFF_FFFF to zero.
- R12: `wake` is high for exactly one cycle per fire, and it rises on the same edge that sets `match_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, nominally 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| wr_count | input | 1 | Load the count and the disable flag from `wr_data` |
| wr_limit | input | 1 | Load the compare value and the disable flag from `wr_data` |
| wr_data | input | 64 | Write word: bit 63 is the disable flag, bits 62:0 are the value |
| clr_match | input | 1 | Clear the sticky match bit |
| rd_count | output | 64 | Disable flag in bit 63 and the running count in bits 62:0 |
| match_flag | output | 1 | Sticky soft-interrupt match bit |
| wake | output | 1 | One-cycle wake pulse on each fire |

## Verification
Faults in the comparator or in the arm register show up in when `wake` fires. An off-by-one compare moves the pulse by one cycle. An arm that is never consumed gives a second pulse within a few cycles once the count is moved below the limit. A disable flag that is lost or stuck shows in `rd_count[63]` on the cycle right after the write. It also shows as a wake that should have been blocked. Errors in the count itself appear at once in `rd_count[62:0]`, either at a load or at the wrap from all ones to zero.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned TK_CNT_W_DEF = 63;
  localparam int unsigned TK_TICK_HZ   = 100_000_000;
endpackage

// File: rtl/tk_count.sv
module tk_count #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (ld) cnt_q <= ld_val;
    else         cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/tk_arm.sv
module tk_arm #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_count,
  input  logic             wr_limit,
  input  logic [CNT_W:0]   wr_data,
  input  logic             consume,
  output logic [CNT_W-1:0] limit_q,
  output logic             armed_q,
  output logic             dis_q
);
  logic [CNT_W-1:0] new_val;
  logic             new_dis;

  assign new_val = wr_data[CNT_W-1:0];
  assign new_dis = wr_data[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      armed_q <= 1'b0;
      dis_q   <= 1'b1;
    end else begin
      if (wr_count || wr_limit) dis_q <= new_dis;
      if (wr_limit) begin
        limit_q <= new_val;
        armed_q <= (new_val != '0) && !new_dis;
      end else if (consume) begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tk_fire.sv
module tk_fire #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] limit,
  input  logic             armed,
  input  logic             dis,
  input  logic             clr,
  output logic             consume,
  output logic             match_q,
  output logic             wake_q
);
  logic hit;
  logic fire;

  assign hit     = armed && (cnt >= limit);
  assign fire    = hit && !dis;
  assign consume = hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= fire;
      if (fire)     match_q <= 1'b1;
      else if (clr) match_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int unsigned CNT_W = tick_pkg::TK_CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_count,
  input  logic         wr_limit,
  input  logic [CNT_W:0] wr_data,
  input  logic         clr_match,
  output logic [CNT_W:0] rd_count,
  output logic         match_flag,
  output logic         wake
);
  localparam int unsigned WORD_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             armed;
  logic             dis;
  logic             consume;

  tk_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .ld(wr_count),
    .ld_val(wr_data[CNT_W-1:0]), .cnt_q(cnt)
  );

  tk_arm #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst(rst), .wr_count(wr_count), .wr_limit(wr_limit),
    .wr_data(wr_data), .consume(consume),
    .limit_q(limit), .armed_q(armed), .dis_q(dis)
  );

  tk_fire #(.CNT_W(CNT_W)) u_fire (
    .clk(clk), .rst(rst), .cnt(cnt), .limit(limit), .armed(armed),
    .dis(dis), .clr(clr_match), .consume(consume),
    .match_q(match_flag), .wake_q(wake)
  );

  assign rd_count = {dis, cnt};

  initial begin
    if (WORD_W < 2) $display("tick_cmp_timer: width too small");
  end
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int unsigned CNT_W = 63
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_count,
  input logic         wr_limit,
  input logic [CNT_W:0] wr_data,
  input logic         clr_match,
  input logic [CNT_W:0] rd_count,
  input logic         match_flag,
  input logic         wake
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr_count |=> rd_count[CNT_W-1:0] == $past(rd_count[CNT_W-1:0]) + 1'b1); // R2
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> rd_count[CNT_W-1:0] == $past(wr_data[CNT_W-1:0])); // R2
  AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_count || wr_limit) |=> rd_count[CNT_W] == $past(wr_data[CNT_W])); // R4
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !clr_match) |=> match_flag); // R10
  AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (rst)
    wake |-> match_flag); // R12
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wake && !$past(wr_limit)) |=> !wake); // R12
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_count(wr_count), .wr_limit(wr_limit),
  .wr_data(wr_data), .clr_match(clr_match), .rd_count(rd_count),
  .match_flag(match_flag), .wake(wake)
);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
  localparam int unsigned CW = 63;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_count = 1'b0;
  logic          wr_limit = 1'b0;
  logic [CW:0]   wr_data = '0;
  logic          clr_match = 1'b0;
  logic [CW:0]   rd_count;
  logic          match_flag;
  logic          wake;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tick_cmp_timer #(.CNT_W(CW)) i_tick_cmp_timer (
    .clk(clk), .rst(rst), .wr_count(wr_count), .wr_limit(wr_limit),
    .wr_data(wr_data), .clr_match(clr_match), .rd_count(rd_count),
    .match_flag(match_flag), .wake(wake)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_count(input logic [CW:0] v);
    wr_count = 1'b1; wr_data = v;
    step();
    wr_count = 1'b0;
  endtask

  task automatic put_limit(input logic [CW:0] v);
    wr_limit = 1'b1; wr_data = v;
    step();
    wr_limit = 1'b0;
  endtask

  task automatic clear_match();
    clr_match = 1'b1;
    step();
    clr_match = 1'b0;
  endtask

  task automatic idle_no_wake(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      step();
      chk(req, {63'd0, wake}, 64'd0);
      chk(req, {63'd0, match_flag}, 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    // R1 reset state
    chk("R1", rd_count, {1'b1, 63'd0});
    chk("R1", {63'd0, match_flag}, 64'd0);
    chk("R1", {63'd0, wake}, 64'd0);
    rst = 1'b0;
    step();
    chk("R1", rd_count, {1'b1, 63'd1});
    repeat (4) step();
    chk("R3", rd_count, {1'b1, 63'd5});

    // R2 load then free run
    put_count({1'b0, 63'h123});
    chk("R2", rd_count, {1'b0, 63'h123});
    repeat (5) step();
    chk("R2", rd_count, {1'b0, 63'h128});

    // R4 flag through count write and limit write
    put_count({1'b1, 63'd7});
    chk("R4", rd_count, {1'b1, 63'd7});
    put_count({1'b0, 63'd0});
    chk("R4", {63'd0, rd_count[63]}, 64'd0);

    // R6 / R7 / R12 sweep of limit offset against the count
    for (int d = -3; d <= 10; d++) begin
      int nf;
      clear_match();
      put_count({1'b0, 63'd100});
      put_limit({1'b0, 63'(100 + d)});
      nf = (d > 1) ? d : 1;
      for (int n = 1; n <= nf + 3; n++) begin
        step();
        if (d <= 0) chk("R7", {63'd0, wake}, {63'd0, (n == nf)});
        else        chk("R6", {63'd0, wake}, {63'd0, (n == nf)});
        chk("R12", {63'd0, match_flag}, {63'd0, (n >= nf)});
      end
    end

    // R10 sticky, then clear
    repeat (3) step();
    chk("R10", {63'd0, match_flag}, 64'd1);
    clear_match();
    chk("R10", {63'd0, match_flag}, 64'd0);

    // R10 fire wins over same-edge clear
    put_count({1'b0, 63'd0});
    put_limit({1'b0, 63'd4});
    clr_match = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      step();
      chk("R10", {63'd0, match_flag}, {63'd0, (n == 4)});
    end
    clr_match = 1'b0;

    // R9 one-shot: count moved below the limit again
    put_count({1'b0, 63'd0});
    put_limit({1'b0, 63'd5});
    repeat (6) step();
    chk("R9", {63'd0, match_flag}, 64'd1);
    clear_match();
    put_count({1'b0, 63'd0});
    idle_no_wake("R9", 20);

    // R5 zero limit
    put_count({1'b0, 63'd0});
    put_limit({1'b0, 63'd0});
    idle_no_wake("R5", 20);

    // R8 limit written with flag set
    put_count({1'b0, 63'd0});
    put_limit({1'b1, 63'd30});
    chk("R4", {63'd0, rd_count[63]}, 64'd1);
    idle_no_wake("R8", 10);
    put_count({1'b0, 63'd10});
    idle_no_wake("R8", 40);

    // R8 arm consumed while disabled
    put_count({1'b0, 63'd0});
    put_limit({1'b0, 63'd20});
    put_count({1'b1, 63'd5});
    chk("R8", {63'd0, rd_count[63]}, 64'd1);
    idle_no_wake("R8", 30);
    put_count({1'b0, 63'd0});
    idle_no_wake("R8", 30);

    // R11 wrap
    put_count({1'b0, 63'h7FFF_FFFF_FFFF_FFFE});
    chk("R11", rd_count, {1'b0, 63'h7FFF_FFFF_FFFF_FFFE});
    step();
    chk("R11", rd_count, {1'b0, 63'h7FFF_FFFF_FFFF_FFFF});
    step();
    chk("R11", rd_count, {1'b0, 63'd0});
    step();
    chk("R2", rd_count, {1'b0, 63'd1});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule